// File: doc/BRIEF.md
# DMA Channel Interrupt Aggregator

This block gathers per-channel interrupt causes from a bank of DMA channels and presents them on a small set of interrupt lines. Each channel reports two kinds of event, a finished descriptor and an error, as single-cycle pulses. Each event is latched into a status word. Every interrupt line keeps its own copy of that status word and its own enable mask, so one line can serve one software agent without touching the view of another.

Channel direction follows channel parity. Even channels move data from memory to a device (transmit) and odd channels move data from a device to memory (receive). For each interrupt line the block forms two summary words, one for transmit and one for receive. Channel n drives bit n/2 of the word that matches its direction. An interrupt line is raised while any bit of its two summary words is set. Software reads status, masks and summaries through a simple register port with a combinational read. It clears causes by writing ones to the status bits.

Register address layout: bits [9:8] give the kind (0 status, 1 mask, 2 transmit summary, 3 receive summary), bits [7:6] give the interrupt line, and bits [5:0] give the channel.

Top module: `dma_irq_aggregator`

## Requirements
- R1: A pulse on a channel's done input sets bit 0, and a pulse on its error input sets bit 6, of that channel's status word for every interrupt line. The bit is readable right after the clock edge that samples the pulse.
- R2: A status write clears exactly the bits written as 1 (bits 0 and 6), and only for the addressed line and channel. Bits written as 0, and the copies held for other lines, keep their value.
- R3: When an event and a write-one-to-clear of the same bit fall in the same cycle, the bit ends set.
- R4: A mask write stores bits 0 and 6 for the addressed line and channel only. Reading the mask returns those two bits, and all other bits read 0.
- R5: For line o, channel n sets bit n/2 of the transmit summary word (kind 2) when n is even, or of the receive summary word (kind 3) when n is odd, whenever its status AND mask is nonzero on line o.
- R6: Interrupt output o is the OR of line o's transmit and receive summary words. It follows status and mask changes in the same cycle they become visible, with no extra register stage.
- R7: After reset every status and mask bit is 0 and every interrupt output is low.
- R8: Writes to summary words are ignored. Status and mask addresses with a channel number at or above the channel count read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| ev_done_i | input | NUM_CH | Per-channel descriptor-finished pulse |
| ev_err_i | input | NUM_CH | Per-channel error pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 10 | Register write address {kind, line, channel} |
| wr_data_i | input | DATA_W | Register write data |
| rd_addr_i | input | 10 | Register read address {kind, line, channel} |
| rd_data_o | output | DATA_W | Combinational read data |
| irq_o | output | NUM_OUT | Interrupt line per output view |

## Verification
A new cause pulse on a channel and a software write-one-to-clear of the same status bit can land in the same clock cycle. The bench provokes this by driving the channel's done pulse together with a status write that clears both cause bits. It then reads the word back after that edge. The done bit must survive while the error bit goes away, and the matching interrupt line must stay high. Other cases show that one line's clear leaves the other lines' copies untouched.

// File: rtl/dirq_pkg.sv
package dirq_pkg;
  // Address field widths; line and channel fields are sized for the maximum supported counts
  localparam int KIND_W     = 2;
  localparam int LINE_FLD_W = 2;
  localparam int CH_FLD_W   = 6;
  localparam int ADDR_W     = KIND_W + LINE_FLD_W + CH_FLD_W;

  // Bit positions of the two causes inside a status or mask word
  localparam int DONE_POS = 0;
  localparam int ERR_POS  = 6;

  typedef enum logic [KIND_W-1:0] {
    KIND_STAT  = 2'd0,
    KIND_MASK  = 2'd1,
    KIND_TXSUM = 2'd2,
    KIND_RXSUM = 2'd3
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e             kind;
    logic [LINE_FLD_W-1:0] line;
    logic [CH_FLD_W-1:0]   ch;
  } reg_addr_t;
endpackage

// File: rtl/dirq_wr_decode.sv
module dirq_wr_decode
  import dirq_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int NUM_OUT = 4
) (
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  output logic [NUM_CH-1:0]   stat_we [NUM_OUT],
  output logic [NUM_CH-1:0]   mask_we [NUM_OUT]
);
  reg_addr_t wa;
  logic      stat_hit;
  logic      mask_hit;

  assign wa       = reg_addr_t'(wr_addr);
  assign stat_hit = wr_en && (wa.kind == KIND_STAT);
  assign mask_hit = wr_en && (wa.kind == KIND_MASK);

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_line
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic sel;
      assign sel           = (wa.line == LINE_FLD_W'(o)) && (wa.ch == CH_FLD_W'(c));
      assign stat_we[o][c] = stat_hit && sel;
      assign mask_we[o][c] = mask_hit && sel;
    end
  end
endmodule

// File: rtl/dirq_cause_cell.sv
module dirq_cause_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_done,
  input  logic ev_err,
  input  logic stat_we,
  input  logic mask_we,
  input  logic wd_done,
  input  logic wd_err,
  output logic st_done,
  output logic st_err,
  output logic mk_done,
  output logic mk_err,
  output logic hit
);
  logic [1:0] st_q, st_d, mk_q, mk_d;
  logic [1:0] set_v, clr_v;
  logic       st_en;

  // index 0 = done, index 1 = error
  assign set_v = {ev_err, ev_done};
  assign clr_v = stat_we ? {wd_err, wd_done} : 2'b00;

  always_comb begin
    // set dominates clear so a fresh event is never dropped
    st_d  = (st_q & ~clr_v) | set_v;
    st_en = |(set_v | clr_v);
    mk_d  = {wd_err, wd_done};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= 2'b00;
    end else if (st_en) begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mk_q <= 2'b00;
    end else if (mask_we) begin
      mk_q <= mk_d;
    end
  end

  assign st_done = st_q[0];
  assign st_err  = st_q[1];
  assign mk_done = mk_q[0];
  assign mk_err  = mk_q[1];
  assign hit     = |(st_q & mk_q);
endmodule

// File: rtl/dirq_summary.sv
module dirq_summary #(
  parameter int NUM_CH = 8,
  localparam int HALF  = NUM_CH / 2
) (
  input  logic [NUM_CH-1:0] hit,
  output logic [HALF-1:0]   tx_word,
  output logic [HALF-1:0]   rx_word,
  output logic              irq
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_route
    if ((c % 2) == 0) begin : g_tx
      assign tx_word[c/2] = hit[c];
    end else begin : g_rx
      assign rx_word[c/2] = hit[c];
    end
  end

  assign irq = (|tx_word) | (|rx_word);
endmodule

// File: rtl/dma_irq_aggregator.sv
module dma_irq_aggregator
  import dirq_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int NUM_OUT = 4,
  parameter int DATA_W  = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_CH-1:0]   ev_done_i,
  input  logic [NUM_CH-1:0]   ev_err_i,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic [ADDR_W-1:0]   rd_addr_i,
  output logic [DATA_W-1:0]   rd_data_o,
  output logic [NUM_OUT-1:0]  irq_o
);
  localparam int HALF      = NUM_CH / 2;
  localparam int CH_IDX_W  = $clog2(NUM_CH);
  localparam int OUT_IDX_W = $clog2(NUM_OUT);

  logic [NUM_CH-1:0] stat_we [NUM_OUT];
  logic [NUM_CH-1:0] mask_we [NUM_OUT];
  logic [NUM_CH-1:0] st_done [NUM_OUT];
  logic [NUM_CH-1:0] st_err  [NUM_OUT];
  logic [NUM_CH-1:0] mk_done [NUM_OUT];
  logic [NUM_CH-1:0] mk_err  [NUM_OUT];
  logic [NUM_CH-1:0] hit     [NUM_OUT];
  logic [HALF-1:0]   tx_w    [NUM_OUT];
  logic [HALF-1:0]   rx_w    [NUM_OUT];
  logic              wr_data_unused;

  assign wr_data_unused = ^wr_data_i;

  dirq_wr_decode #(.NUM_CH(NUM_CH), .NUM_OUT(NUM_OUT)) u_dec (
    .wr_en   (wr_en_i),
    .wr_addr (wr_addr_i),
    .stat_we (stat_we),
    .mask_we (mask_we)
  );

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_line
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      dirq_cause_cell u_cell (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev_done (ev_done_i[c]),
        .ev_err  (ev_err_i[c]),
        .stat_we (stat_we[o][c]),
        .mask_we (mask_we[o][c]),
        .wd_done (wr_data_i[DONE_POS]),
        .wd_err  (wr_data_i[ERR_POS]),
        .st_done (st_done[o][c]),
        .st_err  (st_err[o][c]),
        .mk_done (mk_done[o][c]),
        .mk_err  (mk_err[o][c]),
        .hit     (hit[o][c])
      );
    end

    dirq_summary #(.NUM_CH(NUM_CH)) u_sum (
      .hit     (hit[o]),
      .tx_word (tx_w[o]),
      .rx_word (rx_w[o]),
      .irq     (irq_o[o])
    );
  end

  // Combinational read mux
  reg_addr_t                ra;
  logic [OUT_IDX_W-1:0]     r_line;
  logic [CH_IDX_W-1:0]      r_ch;
  logic                     line_ok;
  logic                     ch_ok;

  assign ra      = reg_addr_t'(rd_addr_i);
  assign r_line  = ra.line[OUT_IDX_W-1:0];
  assign r_ch    = ra.ch[CH_IDX_W-1:0];
  assign line_ok = int'(ra.line) < NUM_OUT;
  assign ch_ok   = int'(ra.ch) < NUM_CH;

  always_comb begin
    rd_data_o = '0;
    if (line_ok) begin
      unique case (ra.kind)
        KIND_STAT: begin
          if (ch_ok) begin
            rd_data_o[DONE_POS] = st_done[r_line][r_ch];
            rd_data_o[ERR_POS]  = st_err[r_line][r_ch];
          end
        end
        KIND_MASK: begin
          if (ch_ok) begin
            rd_data_o[DONE_POS] = mk_done[r_line][r_ch];
            rd_data_o[ERR_POS]  = mk_err[r_line][r_ch];
          end
        end
        KIND_TXSUM: rd_data_o[HALF-1:0] = tx_w[r_line];
        KIND_RXSUM: rd_data_o[HALF-1:0] = rx_w[r_line];
        default:    rd_data_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/dirq_checker.sv
module dirq_checker #(
  parameter int NUM_CH = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] ev_done,
  input logic [NUM_CH-1:0] ev_err,
  input logic [NUM_CH-1:0] done_q0,
  input logic [NUM_CH-1:0] err_q0,
  input logic [NUM_CH-1:0] mdone0,
  input logic [NUM_CH-1:0] merr0,
  input logic [NUM_CH-1:0] mask_we0,
  input logic              irq0
);
  // R1
  done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_done != '0) |=> ((done_q0 & $past(ev_done)) == $past(ev_done)));

  // R3
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_err != '0) |=> ((err_q0 & $past(ev_err)) == $past(ev_err)));

  // R2
  no_spont_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_done == '0) |=> ((done_q0 & ~$past(done_q0)) == '0));

  // R4
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_we0 == '0) |=> ($stable(mdone0) && $stable(merr0)));

  // R6
  irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq0 == (|((done_q0 & mdone0) | (err_q0 & merr0))));
endmodule

bind dma_irq_aggregator dirq_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ev_done  (ev_done_i),
  .ev_err   (ev_err_i),
  .done_q0  (st_done[0]),
  .err_q0   (st_err[0]),
  .mdone0   (mk_done[0]),
  .merr0    (mk_err[0]),
  .mask_we0 (mask_we[0]),
  .irq0     (irq_o[0])
);

// File: tb/tb_dma_irq_aggregator.sv
module tb_dma_irq_aggregator;
  localparam int NCH = 8;
  localparam int NO  = 4;

  logic            clk;
  logic            rst_n;
  logic [NCH-1:0]  ev_done;
  logic [NCH-1:0]  ev_err;
  logic            wr_en;
  logic [9:0]      wr_addr;
  logic [31:0]     wr_data;
  logic [9:0]      rd_addr;
  logic [31:0]     rd_data;
  logic [NO-1:0]   irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  dma_irq_aggregator #(.NUM_CH(NCH), .NUM_OUT(NO), .DATA_W(32)) dut (
    .clk(clk), .rst_n(rst_n), .ev_done_i(ev_done), .ev_err_i(ev_err),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic [7:0]  done;
    logic [7:0]  err;
    logic        we;
    logic [9:0]  waddr;
    logic [31:0] wdata;
    logic [9:0]  raddr;
    logic [31:0] exp;
    logic [3:0]  eirq;
    logic [3:0]  req;
  } vec_t;

  function automatic logic [9:0] ad(input int kind, input int line, input int ch);
    return {kind[1:0], line[1:0], ch[5:0]};
  endfunction

  function automatic vec_t mk(input logic [7:0] d, input logic [7:0] e, input logic w,
                              input logic [9:0] wa, input logic [31:0] wd,
                              input logic [9:0] ra, input logic [31:0] x,
                              input logic [3:0] i, input int r);
    vec_t v;
    v.done = d; v.err = e; v.we = w; v.waddr = wa; v.wdata = wd;
    v.raddr = ra; v.exp = x; v.eirq = i; v.req = r[3:0];
    return v;
  endfunction

  // kinds: 0 status, 1 mask, 2 tx summary, 3 rx summary
  localparam vec_t TBL [18] = '{
    mk(8'h00, 8'h00, 1, ad(1,0,2), 32'h41, ad(1,0,2), 32'h41, 4'b0000, 4),  // R4 mask out0 ch2
    mk(8'h04, 8'h00, 0, 10'h0,     32'h0,  ad(0,0,2), 32'h01, 4'b0001, 1),  // R1 done ch2
    mk(8'h00, 8'h00, 0, 10'h0,     32'h0,  ad(2,0,0), 32'h02, 4'b0001, 5),  // R5 even -> tx bit1
    mk(8'h00, 8'h00, 0, 10'h0,     32'h0,  ad(3,0,0), 32'h00, 4'b0001, 5),  // R5 rx stays 0
    mk(8'h00, 8'h08, 0, 10'h0,     32'h0,  ad(0,1,3), 32'h40, 4'b0001, 1),  // R1 err ch3 on out1
    mk(8'h00, 8'h00, 1, ad(1,1,3), 32'h40, ad(3,1,0), 32'h02, 4'b0011, 5),  // R5 odd -> rx bit1, R6
    mk(8'h00, 8'h00, 1, ad(0,0,2), 32'h40, ad(0,0,2), 32'h01, 4'b0011, 2),  // R2 clearing unset bit
    mk(8'h00, 8'h00, 1, ad(0,0,2), 32'h01, ad(0,0,2), 32'h00, 4'b0010, 2),  // R2 clear done out0
    mk(8'h00, 8'h00, 0, 10'h0,     32'h0,  ad(0,2,2), 32'h01, 4'b0010, 2),  // R2 out2 copy kept
    mk(8'h00, 8'h00, 1, ad(1,1,3), 32'h00, ad(3,1,0), 32'h00, 4'b0000, 6),  // R6 unmask drops irq
    mk(8'h00, 8'h00, 1, ad(1,3,7), 32'hFFFF_FFFF, ad(1,3,7), 32'h41, 4'b0000, 4), // R4 only 0/6
    mk(8'h80, 8'h80, 0, 10'h0,     32'h0,  ad(0,3,7), 32'h41, 4'b1000, 1),  // R1 both causes
    mk(8'h00, 8'h00, 0, 10'h0,     32'h0,  ad(3,3,0), 32'h08, 4'b1000, 5),  // R5 ch7 -> rx bit3
    mk(8'h00, 8'h00, 1, ad(2,3,0), 32'h0F, ad(2,3,0), 32'h00, 4'b1000, 8),  // R8 summary write ignored
    mk(8'h80, 8'h00, 1, ad(0,3,7), 32'h41, ad(0,3,7), 32'h01, 4'b1000, 3),  // R3 event beats clear
    mk(8'h00, 8'h00, 1, ad(1,3,12), 32'h41, ad(1,3,12), 32'h00, 4'b1000, 8), // R8 channel out of range
    mk(8'h00, 8'h00, 0, 10'h0,     32'h0,  ad(0,3,12), 32'h00, 4'b1000, 8), // R8 status out of range
    mk(8'h00, 8'h00, 1, ad(0,3,7), 32'h01, ad(0,3,7), 32'h00, 4'b0000, 6)   // R6 clear drops irq
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; ev_done = '0; ev_err = '0; wr_en = 1'b0;
    wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R7 reset state
    rd_addr = ad(0, 0, 2); #1;
    check("R7 status after reset", rd_data, 32'h0);
    check("R7 irq after reset", {28'h0, irq}, 32'h0);
    rd_addr = ad(1, 0, 2); #1;
    check("R7 mask after reset", rd_data, 32'h0);

    for (int i = 0; i < 18; i++) begin
      @(negedge clk);
      ev_done = TBL[i].done; ev_err = TBL[i].err;
      wr_en = TBL[i].we; wr_addr = TBL[i].waddr; wr_data = TBL[i].wdata;
      @(posedge clk);
      #1;
      ev_done = '0; ev_err = '0; wr_en = 1'b0;
      rd_addr = TBL[i].raddr;
      #1;
      check($sformatf("R%0d vec %0d rdata", TBL[i].req, i), rd_data, TBL[i].exp);
      check($sformatf("R%0d vec %0d irq", TBL[i].req, i), {28'h0, irq}, {28'h0, TBL[i].eirq});
    end

    // R3 on line 0: clear both bits while a new error arrives on ch5
    @(negedge clk);
    wr_en = 1'b1; wr_addr = ad(1, 0, 5); wr_data = 32'h40;
    @(posedge clk); #1; wr_en = 1'b0;
    @(negedge clk);
    ev_err = 8'h20; wr_en = 1'b1; wr_addr = ad(0, 0, 5); wr_data = 32'h41;
    @(posedge clk); #1; ev_err = '0; wr_en = 1'b0;
    rd_addr = ad(0, 0, 5); #1;
    check("R3 error kept on collision", rd_data, 32'h40);
    check("R3 irq line0 held", {31'h0, irq[0]}, 32'h1);
    rd_addr = ad(3, 0, 0); #1;
    check("R5 ch5 -> rx bit2", rd_data, 32'h04);

    // R7 reset in mid-run wipes status and mask
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    rd_addr = ad(0, 2, 2); #1;
    check("R7 status cleared by reset", rd_data, 32'h0);
    rd_addr = ad(1, 0, 5); #1;
    check("R7 mask cleared by reset", rd_data, 32'h0);
    check("R7 irq low after reset", {28'h0, irq}, 32'h0);

    finish_run();
  end
endmodule